// File: doc/BRIEF.md
# External Bus Width Adapter

This block turns 32-bit word requests from inside the chip into cycles on an external system bus. The bus is 64 bits wide. At run time it can be used at full width or at its low 32 bits only. The adapter decides which data lane each word uses and sets the byte enables to match. It decodes the top address bits into one-hot bank selects. It inserts a chosen number of quiet cycles after each access.

Completion can be timed in one of two ways:
- **Pipelined:** read data is taken a fixed, programmable number of cycles after the address cycle.
- **Slow:** the address is held until the device raises its acknowledge.

A request may carry one word or a pair of consecutive words. In full-width mode, a pair that starts at an even address travels as a single beat. In every other case a pair takes two beats.

The mode, the pipe depth and the idle count come in on configuration inputs. The adapter samples them when it accepts a request. The request side uses a valid/ready handshake. One request is outstanding at a time, and its completion is reported by a one-cycle response pulse.

Top module: `ext_bus_width_adapter`

## Requirements
- R1: `cfg_wide`, `cfg_pipe`, `cfg_depth` and `cfg_idle` are sampled in the cycle a request is accepted. Changing them while that request is in progress has no effect on it. `cfg_wide`=1 selects the 64-bit bus and 0 selects the 32-bit bus.
- R2: Lane steering in 64-bit mode depends on the word address:
  - A word at an even address uses `bus_wdata[31:0]` with `bus_be`=8'h0F.
  - A word at an odd address uses `bus_wdata[63:32]` with `bus_be`=8'hF0.
  - In 32-bit mode every word uses `bus_wdata[31:0]` with `bus_be`=8'h0F.
  - Any lane not in use carries zero write data.
  - On reads the write data is zero.
- R3: A pair request (`req_pair`=1) carries the word for address A in `req_wdata[31:0]` and the word for A+1 in `req_wdata[63:32]`:
  - In 64-bit mode with A even, it becomes one beat at address A with `bus_be`=8'hFF.
  - Otherwise it becomes two beats, at A and then A+1.
  - A pair read returns {word(A+1), word(A)} on `rsp_rdata`.
  - A single read returns {32'h0, word(A)}.
- R4: While `bus_strobe` is high, `bus_bank` is one-hot and its set bit has index `bus_addr[31:29]`. While `bus_strobe` is low, `bus_bank`, `bus_addr` and `bus_be` are zero and `bus_write` is low.
- R5: After each beat completes, the bus stays quiet (strobe low) for `cfg_idle` cycles (0 to 3):
  - After the last beat of a request, `req_ready` returns `cfg_idle` cycles after the response cycle, or in the response cycle itself when `cfg_idle` is 0.
  - When a pair takes two beats, the second beat's strobe follows the completion of the first after exactly `cfg_idle` quiet cycles.
- R6: With `cfg_pipe`=1, each beat asserts `bus_strobe` for exactly one cycle. With `cfg_depth`=d, the read data is sampled at the end of the (d+1)th cycle after the address cycle. `bus_ack` has no effect in this mode.
- R7: With `cfg_pipe`=0:
  - `bus_strobe` and the beat outputs stay unchanged until `bus_ack` is high at a clock edge during the strobe.
  - Read data is sampled at that edge.
  - `bus_ack` while the strobe is low has no effect.
- R8: A request is accepted at a clock edge where `req_valid` and `req_ready` are both high. The first beat's strobe appears in the next cycle. `req_ready` stays low while an access is in progress.
- R9: `rsp_valid` is high for exactly one cycle, the cycle after the last beat completes. This holds for writes as well as reads.
- R10: During and after reset, and before the first request, `req_ready` is high and `bus_strobe` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wide | input | 1 | 1: 64-bit bus, 0: 32-bit bus |
| cfg_pipe | input | 1 | 1: pipelined completion, 0: acknowledge-paced completion |
| cfg_depth | input | 2 | Pipe depth minus one |
| cfg_idle | input | 2 | Quiet cycles after each beat |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Adapter can accept a request |
| req_write | input | 1 | 1: write, 0: read |
| req_pair | input | 1 | Request covers two consecutive words |
| req_addr | input | 32 | Word address of the first word |
| req_wdata | input | 64 | Write words: first word low, second word high |
| rsp_valid | output | 1 | Request complete (one cycle) |
| rsp_rdata | output | 64 | Read result |
| bus_strobe | output | 1 | Address cycle / held address (slow mode) |
| bus_write | output | 1 | Beat direction |
| bus_addr | output | 32 | Beat word address |
| bus_bank | output | 8 | One-hot bank select |
| bus_be | output | 8 | Byte enables |
| bus_wdata | output | 64 | Write data on the lanes |
| bus_rdata | input | 64 | Read data from the bus |
| bus_ack | input | 1 | Device acknowledge for slow accesses |

## Verification
The stimulus covers the cases that separate a correct adapter from a plausible wrong one:
- Single words at even and at odd addresses in both widths. These show whether lane choice follows the address parity, and whether the 32-bit mode correctly ignores parity.
- Pairs with even and odd bases. These separate the merged single beat from the two-beat split.
- Each pipe depth, with the bus driving data only in the one capture cycle and deliberate junk in the cycles around it. Sampling one cycle early or late therefore returns the junk.
- Slow accesses with zero to three wait cycles, plus acknowledges raised during quiet cycles. These show that completion follows the acknowledge only while the strobe is up.
- A sweep over all eight address tops, which checks the bank decode.

// File: rtl/ebw_pkg.sv
package ebw_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ADDR = 2'd1,
    SQ_WAIT = 2'd2,
    SQ_GAP  = 2'd3
  } sq_state_t;

  // A pair fits one beat only on the wide bus from an even base.
  function automatic logic pair_merges(input logic wide, input logic pair,
                                       input logic base_odd);
    return pair && wide && !base_odd;
  endfunction

  function automatic logic pair_splits(input logic wide, input logic pair,
                                       input logic base_odd);
    return pair && !pair_merges(wide, pair, base_odd);
  endfunction

  // Lane holding a lone word: high lane only for odd words on the wide bus.
  function automatic logic word_uses_high_lane(input logic wide, input logic odd);
    return wide && odd;
  endfunction

endpackage

// File: rtl/ebw_bank_decode.sv
module ebw_bank_decode #(
  parameter int ADDR_W   = 32,
  parameter int SEL_BITS = 3
) (
  input  logic                       en,
  input  logic [ADDR_W-1:0]          addr,
  output logic [(1<<SEL_BITS)-1:0]   bank
);
  localparam int BANKS = 1 << SEL_BITS;

  logic [SEL_BITS-1:0] field;
  assign field = addr[ADDR_W-1 -: SEL_BITS];

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    assign bank[g] = en && (field == SEL_BITS'(g));
  end
endmodule

// File: rtl/ebw_lane_steer.sv
module ebw_lane_steer
  import ebw_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                  wide,
  input  logic                  merged,
  input  logic                  odd,
  input  logic                  drive_en,
  input  logic                  wr_en,
  input  logic [WORD_W-1:0]     word,
  input  logic [2*WORD_W-1:0]   pair_data,
  input  logic [2*WORD_W-1:0]   rdata,
  output logic [2*WORD_W-1:0]   wdata,
  output logic [2*WORD_W/8-1:0] be,
  output logic [WORD_W-1:0]     rd_word
);
  localparam int LANES = 2;
  localparam int BPL   = WORD_W / 8;

  logic [LANES-1:0] lane_on;
  logic             hi_lane;

  assign hi_lane = word_uses_high_lane(wide, odd);

  always_comb begin
    if (!drive_en)    lane_on = '0;
    else if (merged)  lane_on = '1;
    else if (hi_lane) lane_on = 2'b10;
    else              lane_on = 2'b01;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign be[l*BPL +: BPL] = {BPL{lane_on[l]}};
    assign wdata[l*WORD_W +: WORD_W] =
      (wr_en && lane_on[l]) ? (merged ? pair_data[l*WORD_W +: WORD_W] : word) : '0;
  end

  assign rd_word = hi_lane ? rdata[WORD_W +: WORD_W] : rdata[WORD_W-1:0];
endmodule

// File: rtl/ebw_seq.sv
module ebw_seq
  import ebw_pkg::*;
#(
  parameter int DEPTH_W = 2,
  parameter int IDLE_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               cfg_pipe,
  input  logic [DEPTH_W-1:0] cfg_depth,
  input  logic [IDLE_W-1:0]  cfg_idle,
  input  logic               two_beats,
  input  logic               bus_ack,
  output logic               strobe,
  output logic               beat_idx,
  output logic               beat_done,
  output logic               last_done,
  output logic               rsp_valid,
  output logic               ready
);
  localparam int CNT_W = (DEPTH_W > IDLE_W) ? DEPTH_W : IDLE_W;

  sq_state_t          st;
  sq_state_t          after_st;
  logic               pipe_q;
  logic [DEPTH_W-1:0] depth_q;
  logic [IDLE_W-1:0]  idle_q;
  logic               two_q;
  logic               resume_q;
  logic [CNT_W-1:0]   cnt;
  logic               more;

  assign strobe    = (st == SQ_ADDR);
  assign ready     = (st == SQ_IDLE);
  assign beat_done = (st == SQ_ADDR && !pipe_q && bus_ack) ||
                     (st == SQ_WAIT && cnt == '0);
  assign more      = two_q && !beat_idx;
  assign last_done = beat_done && !more;

  always_comb begin
    if (idle_q != '0) after_st = SQ_GAP;
    else if (more)    after_st = SQ_ADDR;
    else              after_st = SQ_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SQ_IDLE;
      pipe_q    <= 1'b0;
      depth_q   <= '0;
      idle_q    <= '0;
      two_q     <= 1'b0;
      resume_q  <= 1'b0;
      cnt       <= '0;
      beat_idx  <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= last_done;
      if (beat_done) begin
        st       <= after_st;
        cnt      <= CNT_W'(idle_q) - CNT_W'(1);
        resume_q <= more;
        if (more) beat_idx <= 1'b1;
      end else begin
        case (st)
          SQ_IDLE: if (start) begin
            pipe_q   <= cfg_pipe;
            depth_q  <= cfg_depth;
            idle_q   <= cfg_idle;
            two_q    <= two_beats;
            beat_idx <= 1'b0;
            st       <= SQ_ADDR;
          end
          SQ_ADDR: if (pipe_q) begin
            st  <= SQ_WAIT;
            cnt <= CNT_W'(depth_q);
          end
          SQ_WAIT: cnt <= cnt - CNT_W'(1);
          SQ_GAP: begin
            if (cnt == '0) st <= resume_q ? SQ_ADDR : SQ_IDLE;
            else           cnt <= cnt - CNT_W'(1);
          end
          default: st <= SQ_IDLE;
        endcase
      end
    end
  end

  // R6
  pipe_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && pipe_q) |=> !strobe);

  // R7
  slow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !pipe_q && !bus_ack) |=> strobe);

  // R5
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && idle_q != '0) |=> !strobe);

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> !ready);
endmodule

// File: rtl/ext_bus_width_adapter.sv
module ext_bus_width_adapter
  import ebw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 32,
  parameter int BANK_BITS = 3,
  parameter int DEPTH_W   = 2,
  parameter int IDLE_W    = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_wide,
  input  logic                           cfg_pipe,
  input  logic [DEPTH_W-1:0]             cfg_depth,
  input  logic [IDLE_W-1:0]              cfg_idle,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic                           req_write,
  input  logic                           req_pair,
  input  logic [ADDR_W-1:0]              req_addr,
  input  logic [2*WORD_W-1:0]            req_wdata,
  output logic                           rsp_valid,
  output logic [2*WORD_W-1:0]            rsp_rdata,
  output logic                           bus_strobe,
  output logic                           bus_write,
  output logic [ADDR_W-1:0]              bus_addr,
  output logic [(1<<BANK_BITS)-1:0]      bus_bank,
  output logic [2*WORD_W/8-1:0]          bus_be,
  output logic [2*WORD_W-1:0]            bus_wdata,
  input  logic [2*WORD_W-1:0]            bus_rdata,
  input  logic                           bus_ack
);
  localparam int BUS_W = 2 * WORD_W;

  logic              fire;
  logic [ADDR_W-1:0] addr_q;
  logic              write_q;
  logic              wide_q;
  logic              merged_q;
  logic [BUS_W-1:0]  wdata_q;
  logic [BUS_W-1:0]  rdata_q;

  logic              beat_idx;
  logic              beat_done;
  logic              last_done;
  logic [ADDR_W-1:0] beat_addr;
  logic [WORD_W-1:0] beat_word;
  logic [WORD_W-1:0] rd_word;

  assign fire = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      write_q  <= 1'b0;
      wide_q   <= 1'b0;
      merged_q <= 1'b0;
      wdata_q  <= '0;
      rdata_q  <= '0;
    end else if (fire) begin
      addr_q   <= req_addr;
      write_q  <= req_write;
      wide_q   <= cfg_wide;
      merged_q <= pair_merges(cfg_wide, req_pair, req_addr[0]);
      wdata_q  <= req_wdata;
      rdata_q  <= '0;
    end else if (beat_done && !write_q) begin
      if (merged_q)      rdata_q                   <= bus_rdata;
      else if (beat_idx) rdata_q[WORD_W +: WORD_W] <= rd_word;
      else               rdata_q[WORD_W-1:0]       <= rd_word;
    end
  end

  ebw_seq #(.DEPTH_W(DEPTH_W), .IDLE_W(IDLE_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (fire),
    .cfg_pipe  (cfg_pipe),
    .cfg_depth (cfg_depth),
    .cfg_idle  (cfg_idle),
    .two_beats (pair_splits(cfg_wide, req_pair, req_addr[0])),
    .bus_ack   (bus_ack),
    .strobe    (bus_strobe),
    .beat_idx  (beat_idx),
    .beat_done (beat_done),
    .last_done (last_done),
    .rsp_valid (rsp_valid),
    .ready     (req_ready)
  );

  assign beat_addr = addr_q + ADDR_W'(beat_idx);
  assign beat_word = beat_idx ? wdata_q[WORD_W +: WORD_W] : wdata_q[WORD_W-1:0];
  assign bus_addr  = bus_strobe ? beat_addr : '0;
  assign bus_write = bus_strobe && write_q;
  assign rsp_rdata = rdata_q;

  ebw_bank_decode #(.ADDR_W(ADDR_W), .SEL_BITS(BANK_BITS)) u_bank (
    .en   (bus_strobe),
    .addr (beat_addr),
    .bank (bus_bank)
  );

  ebw_lane_steer #(.WORD_W(WORD_W)) u_lane (
    .wide      (wide_q),
    .merged    (merged_q),
    .odd       (beat_addr[0]),
    .drive_en  (bus_strobe),
    .wr_en     (bus_write),
    .word      (beat_word),
    .pair_data (wdata_q),
    .rdata     (bus_rdata),
    .wdata     (bus_wdata),
    .be        (bus_be),
    .rd_word   (rd_word)
  );

  // R4
  bank_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe |-> ($countones(bus_bank) == 1 && bus_bank[bus_addr[ADDR_W-1 -: BANK_BITS]]));

  // R4
  bank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_strobe |-> (bus_bank == '0 && bus_be == '0));

  // R2
  narrow_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && !wide_q) |-> (bus_be[2*WORD_W/8-1 -: WORD_W/8] == '0));

  // R9
  rsp_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_done |=> rsp_valid);
endmodule

// File: tb/test_ext_bus_width_adapter.sv
`timescale 1ns/1ps
module test_ext_bus_width_adapter;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        cfg_wide, cfg_pipe;
  logic [1:0]  cfg_depth, cfg_idle;
  logic        req_valid, req_ready, req_write, req_pair;
  logic [31:0] req_addr;
  logic [63:0] req_wdata;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        bus_strobe, bus_write;
  logic [31:0] bus_addr;
  logic [7:0]  bus_bank, bus_be;
  logic [63:0] bus_wdata, bus_rdata;
  logic        bus_ack;

  ext_bus_width_adapter i_ext_bus_width_adapter (.*);

  int n_cmp = 0;
  int n_bad = 0;
  localparam logic [63:0] JUNK = 64'hF00D_0BAD_DEAD_BEEF;

  task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h @%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pat(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A17_C3E9;
  endfunction

  task automatic exp_cycle(string tag, bit s, bit w, logic [31:0] a, logic [7:0] bk,
                           logic [7:0] be, logic [63:0] wd, bit rdy, bit rv,
                           bit chk_rd, logic [63:0] rd);
    cmp(tag, "bus_strobe", bus_strobe, s);
    cmp(tag, "bus_write",  bus_write, w);
    cmp(tag, "bus_addr",   bus_addr, a);
    cmp(tag, "bus_bank R4", bus_bank, bk);
    cmp(tag, "bus_be R2",  bus_be, be);
    cmp(tag, "bus_wdata R2", bus_wdata, wd);
    cmp(tag, "req_ready R8", req_ready, rdy);
    cmp(tag, "rsp_valid R9", rsp_valid, rv);
    if (chk_rd) cmp(tag, "rsp_rdata R3", rsp_rdata, rd);
  endtask

  task automatic quiet(string tag, bit rdy, bit rv, bit chk_rd, logic [63:0] rd);
    exp_cycle(tag, 0, 0, 0, 0, 0, 0, rdy, rv, chk_rd, rd);
  endtask

  // Entered at a negedge where the adapter is expected ready; leaves at the
  // negedge where ready is back (already checked).
  task automatic do_req(string tag, bit wr, logic [31:0] addr, bit pair,
                        logic [63:0] wd, bit wide, bit pipe, int depth,
                        int idle, int waitn);
    bit merged = pair && wide && !addr[0];
    int nb = (pair && !merged) ? 2 : 1;
    logic [63:0] exp_rd = pair ? {pat(addr + 1), pat(addr)} : {32'h0, pat(addr)};
    cmp(tag, "req_ready before accept R8", req_ready, 1);
    cfg_wide = wide; cfg_pipe = pipe; cfg_depth = 2'(depth); cfg_idle = 2'(idle);
    req_valid = 1; req_write = wr; req_pair = pair; req_addr = addr; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    // R1: scramble configuration after acceptance; must not matter.
    req_valid = 0; cfg_wide = ~wide; cfg_pipe = ~pipe;
    cfg_depth = ~2'(depth); cfg_idle = ~2'(idle);
    req_addr = 32'h1357_9BDF; req_pair = ~pair; req_write = ~wr;
    for (int b = 0; b < nb; b++) begin
      logic [31:0] ba = merged ? addr : addr + b;
      logic [31:0] word = (b == 0) ? wd[31:0] : wd[63:32];
      logic [7:0]  bk = 8'(1) << ba[31:29];
      logic [7:0]  be;
      logic [63:0] ewd;
      logic [63:0] resp = wide ? {pat(ba | 32'h1), pat(ba & ~32'h1)}
                               : {32'hBAD0_BAD0, pat(ba)};
      if (merged)              begin be = 8'hFF; ewd = wd; end
      else if (wide && ba[0])  begin be = 8'hF0; ewd = {word, 32'h0}; end
      else                     begin be = 8'h0F; ewd = {32'h0, word}; end
      if (!wr) ewd = '0;
      if (pipe) begin
        exp_cycle({tag, " R6 addr"}, 1, wr, ba, bk, be, ewd, 0, 0, 0, 0);
        bus_ack = 1; bus_rdata = JUNK;
        for (int k = 1; k <= depth + 1; k++) begin
          @(negedge clk);
          quiet({tag, " R6 wait"}, 0, 0, 0, 0);
          bus_rdata = (k == depth + 1) ? resp : JUNK;
          bus_ack = k[0];
        end
      end else begin
        for (int w = 0; w <= waitn; w++) begin
          if (w > 0) @(negedge clk);
          exp_cycle({tag, " R7 hold"}, 1, wr, ba, bk, be, ewd, 0, 0, 0, 0);
          bus_ack = (w == waitn);
          bus_rdata = (w == waitn) ? resp : JUNK;
        end
      end
      @(negedge clk);
      if (b < nb - 1) begin
        for (int g = 0; g < idle; g++) begin
          quiet({tag, " R5 gap"}, 0, 0, 0, 0);
          bus_ack = 1; bus_rdata = JUNK;
          @(negedge clk);
        end
      end
    end
    for (int g = 0; g <= idle; g++) begin
      quiet({tag, " R5 R9 tail"}, g == idle, g == 0, g == 0 && !wr, exp_rd);
      bus_ack = 1; bus_rdata = JUNK;
      if (g < idle) @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired (R8) actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; cfg_wide = 0; cfg_pipe = 1; cfg_depth = 0; cfg_idle = 0;
    req_valid = 0; req_write = 0; req_pair = 0; req_addr = 0; req_wdata = 0;
    bus_rdata = JUNK; bus_ack = 0;
    repeat (3) @(negedge clk);
    quiet("R10 in reset", 1, 0, 0, 0);
    rst_n = 1;
    @(negedge clk);
    quiet("R10 after reset", 1, 0, 0, 0);
    cmp("R10", "rsp_rdata reset", rsp_rdata, 64'h0);

    do_req("R1 R6 narrow rd d0",   0, 32'h0000_0010, 0, 0, 0, 1, 0, 0, 0);
    do_req("R6 narrow wr d3",      1, 32'h2000_0005, 0, 64'h0_CAFE_0001, 0, 1, 3, 2, 0);
    do_req("R2 wide rd even d1",   0, 32'h4000_0100, 0, 0, 1, 1, 1, 0, 0);
    do_req("R2 wide rd odd d2",    0, 32'h6000_0101, 0, 0, 1, 1, 2, 1, 0);
    do_req("R2 wide wr odd",       1, 32'h6000_0203, 0, 64'h0_1111_2222, 1, 1, 0, 0, 0);
    do_req("R2 wide wr even",      1, 32'h6000_0204, 0, 64'h0_3333_4444, 1, 1, 1, 1, 0);
    do_req("R3 merged rd",         0, 32'h8000_0200, 1, 0, 1, 1, 0, 3, 0);
    do_req("R3 merged wr",         1, 32'h8000_0210, 1, 64'hAAAA_5555_1234_8765, 1, 1, 2, 0, 0);
    do_req("R3 R5 wide pair odd",  0, 32'hA000_0301, 1, 0, 1, 1, 1, 1, 0);
    do_req("R3 narrow pair wr",    1, 32'hC000_0400, 1, 64'h0BB0_0BB0_0CC0_0CC0, 0, 1, 0, 0, 0);
    do_req("R3 narrow pair rd",    0, 32'hC000_0401, 1, 0, 0, 1, 3, 2, 0);
    do_req("R7 slow narrow w0",    0, 32'hE000_0010, 0, 0, 0, 0, 0, 0, 0);
    do_req("R7 slow wide odd w3",  0, 32'hE000_0021, 0, 0, 1, 0, 0, 2, 3);
    do_req("R7 slow pair wr w1",   1, 32'h2000_0031, 1, 64'h7777_8888_9999_AAAA, 1, 0, 0, 0, 1);
    do_req("R7 slow merged rd w2", 0, 32'h4000_0040, 1, 0, 1, 0, 0, 3, 2);
    for (int bk = 0; bk < 8; bk++)
      do_req("R4 bank sweep", 0, {3'(bk), 29'h40}, 0, 0, 1, 1, bk % 4, bk % 2, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule